// File: doc/BRIEF.md
# Flash Status Register Read Interface

This block keeps the eight-bit status word of a parallel NOR flash controller and chooses what the 16-bit read data bus carries. It accepts command bytes from the bus write path and event strobes from the program/erase engine, which lies outside the block. The memory array and the analog supply monitor are also outside; they appear only as inputs. Error flags latch until software clears them. Busy, suspend and buffered-programming bits follow the engine's live state.

Reads in status mode return a snapshot of the word, not the live value. The snapshot is taken at the start of a read. In asynchronous mode that is the first falling edge of chip enable or output enable. In burst mode only a falling chip enable or a falling address-valid strobe refreshes it. The strobe pins come in already synchronised to `clk`. Outside status mode the bus carries the array read data unchanged.

Top module: `nor_status_port`

## Requirements
- R1: After reset the block is in array mode, so the bus carries `array_rd`, and the status snapshot holds 0x80.
- R2: Status bit 7 is 1 while `eng_busy` is low and 0 while it is high.
- R3: Status bits 5:4 encode the result: 00 success, 01 program failure (`evt_prog_fail`), 10 erase failure (`evt_erase_fail`), 11 command sequence error.
- R4: After erase setup 0x20 the next command must be 0xD0, and after lock setup 0x60 the next must be 0x01. Any other byte is not executed: it sets bits 5 and 4 and puts the block in status mode.
- R5: Bit 6 follows `eng_erase_susp`, bit 2 follows `eng_prog_susp`, and bit 0 follows `eng_bufprog_busy`.
- R6: Bit 3 latches on `evt_supply_fault` and bit 1 latches on `evt_lock_abort`.
- R7: In status mode the bus carries the snapshot in bits 7:0, with zero in every bit above.
- R8: Commands 0x70 (read status), 0x40 (program), and a confirmed erase or lock each select status mode. 0xFF selects array mode. Any other code received outside a setup has no effect on the mode.
- R9: In asynchronous mode the snapshot is taken on the first falling edge of `ce_n` or `oe_n`. A later fall of the other pin does not retake it. A rise of `oe_n` or `ce_n` re-arms the capture.
- R10: In burst mode (`burst_mode`=1) the snapshot changes only on a falling `ce_n` or a falling `adv_n`; toggling `oe_n` does not change it.
- R11: Error bits 5, 4, 3 and 1 stay set across suspend and resume until a clear-status command 0x50.
- R12: Clear-status 0x50 clears only bits 5, 4, 3 and 1. An error event in the same cycle as the clear leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_code | input | 8 | Command byte |
| eng_busy | input | 1 | Program or erase is running |
| eng_erase_susp | input | 1 | An erase is suspended |
| eng_prog_susp | input | 1 | A program is suspended |
| eng_bufprog_busy | input | 1 | Buffered factory programming is in progress |
| evt_prog_fail | input | 1 | Pulse: program ended with an error |
| evt_erase_fail | input | 1 | Pulse: erase ended with an error |
| evt_supply_fault | input | 1 | Pulse: supply was out of range during an operation |
| evt_lock_abort | input | 1 | Pulse: operation aborted on a locked block |
| burst_mode | input | 1 | 1 selects synchronous burst read rules |
| ce_n | input | 1 | Chip enable, active low, synchronised |
| oe_n | input | 1 | Output enable, active low, synchronised |
| adv_n | input | 1 | Address-valid strobe, active low, synchronised |
| array_rd | input | BUS_W | Read data from the memory array |
| dq_rd | output | BUS_W | Read data bus |

## Verification
The bench builds the block with the default 16-bit bus, so the zero padding above the status byte is visible in every status read. Directed scenarios walk each command path, including both setup sequences broken by a wrong second byte. They also cover an error that outlives a suspend and resume, and a clear that lands in the same cycle as an event. The snapshot tests change the status word between strobe edges, which separates a first-edge capture from a later edge in asynchronous mode, and separates `oe_n` toggles from `adv_n` and `ce_n` falls in burst mode.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned CMD_W  = 8;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

    // status bit positions (decoded by the host, so fixed)
    localparam int unsigned B_READY   = 7;
    localparam int unsigned B_ESUSP   = 6;
    localparam int unsigned B_ERASE   = 5;
    localparam int unsigned B_PROG    = 4;
    localparam int unsigned B_SUPPLY  = 3;
    localparam int unsigned B_PSUSP   = 2;
    localparam int unsigned B_LOCK    = 1;
    localparam int unsigned B_BUFPROG = 0;

    // command bytes
    localparam logic [CMD_W-1:0] CMD_RD_ARRAY    = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_RD_STATUS   = 8'h70;
    localparam logic [CMD_W-1:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [CMD_W-1:0] CMD_PROGRAM     = 8'h40;
    localparam logic [CMD_W-1:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [CMD_W-1:0] CMD_ERASE_CFM   = 8'hD0;
    localparam logic [CMD_W-1:0] CMD_LOCK_SETUP  = 8'h60;
    localparam logic [CMD_W-1:0] CMD_LOCK_CFM    = 8'h01;

    typedef enum logic [1:0] {
        SETUP_NONE  = 2'd0,
        SETUP_ERASE = 2'd1,
        SETUP_LOCK  = 2'd2
    } setup_e;

    // packed order: erase is bit 3, prog bit 2, supply bit 1, lock bit 0
    typedef struct packed {
        logic erase;
        logic prog;
        logic supply;
        logic lock;
    } err_t;

endpackage

// File: rtl/nsr_cmd_decode.sv
module nsr_cmd_decode
    import nsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             status_mode,
    output logic             clr_pulse,
    output logic             seq_err_pulse,
    output setup_e           setup_state
);

    typedef struct packed {
        setup_e setup;
        logic   status_mode;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        clr_pulse     = 1'b0;
        seq_err_pulse = 1'b0;
        if (cmd_valid) begin
            unique case (st_q.setup)
                SETUP_ERASE: begin
                    st_d.setup       = SETUP_NONE;
                    st_d.status_mode = 1'b1;
                    seq_err_pulse    = (cmd_code != CMD_ERASE_CFM);
                end
                SETUP_LOCK: begin
                    st_d.setup       = SETUP_NONE;
                    st_d.status_mode = 1'b1;
                    seq_err_pulse    = (cmd_code != CMD_LOCK_CFM);
                end
                default: begin
                    case (cmd_code)
                        CMD_RD_ARRAY:    st_d.status_mode = 1'b0;
                        CMD_RD_STATUS:   st_d.status_mode = 1'b1;
                        CMD_PROGRAM:     st_d.status_mode = 1'b1;
                        CMD_CLR_STATUS:  clr_pulse        = 1'b1;
                        CMD_ERASE_SETUP: st_d.setup       = SETUP_ERASE;
                        CMD_LOCK_SETUP:  st_d.setup       = SETUP_LOCK;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.setup       <= SETUP_NONE;
            st_q.status_mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_mode = st_q.status_mode;
    assign setup_state = st_q.setup;

endmodule

// File: rtl/nsr_err_flags.sv
module nsr_err_flags
    import nsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic seq_err,
    input  logic prog_fail,
    input  logic erase_fail,
    input  logic supply_fault,
    input  logic lock_abort,
    output err_t err
);

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr) begin
            err_d = '0;
        end
        // events land after the clear so a coincident event survives
        if (seq_err) begin
            err_d.erase = 1'b1;
            err_d.prog  = 1'b1;
        end
        if (prog_fail)    err_d.prog   = 1'b1;
        if (erase_fail)   err_d.erase  = 1'b1;
        if (supply_fault) err_d.supply = 1'b1;
        if (lock_abort)   err_d.lock   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/nsr_snapshot.sv
module nsr_snapshot #(
    parameter int unsigned          SNAP_W  = 8,
    parameter logic [SNAP_W-1:0]    RST_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SNAP_W-1:0] live,
    input  logic              burst_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    output logic [SNAP_W-1:0] snap
);

    typedef struct packed {
        logic              ce;
        logic              oe;
        logic              adv;
        logic              held;
        logic [SNAP_W-1:0] val;
    } snap_state_t;

    snap_state_t s_d, s_q;

    logic ce_fall, oe_fall, adv_fall, ce_rise, oe_rise;
    logic capture;

    always_comb begin
        ce_fall  = s_q.ce  & ~ce_n;
        oe_fall  = s_q.oe  & ~oe_n;
        adv_fall = s_q.adv & ~adv_n;
        ce_rise  = ~s_q.ce & ce_n;
        oe_rise  = ~s_q.oe & oe_n;

        if (burst_mode) begin
            capture = ce_fall | adv_fall;
        end else begin
            capture = (ce_fall | oe_fall) & ~s_q.held;
        end

        s_d     = s_q;
        s_d.ce  = ce_n;
        s_d.oe  = oe_n;
        s_d.adv = adv_n;
        if (capture) begin
            s_d.val  = live;
            s_d.held = 1'b1;
        end else if (ce_rise | oe_rise) begin
            s_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ce   <= 1'b1;
            s_q.oe   <= 1'b1;
            s_q.adv  <= 1'b1;
            s_q.held <= 1'b0;
            s_q.val  <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap = s_q.val;

endmodule

// File: rtl/nor_status_port.sv
module nor_status_port
    import nsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             eng_busy,
    input  logic             eng_erase_susp,
    input  logic             eng_prog_susp,
    input  logic             eng_bufprog_busy,
    input  logic             evt_prog_fail,
    input  logic             evt_erase_fail,
    input  logic             evt_supply_fault,
    input  logic             evt_lock_abort,
    input  logic             burst_mode,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             adv_n,
    input  logic [BUS_W-1:0] array_rd,
    output logic [BUS_W-1:0] dq_rd
);

    localparam int unsigned PAD_W = (BUS_W > STAT_W) ? BUS_W - STAT_W : 1;

    logic              status_mode;
    logic              clr_pulse;
    logic              seq_err_pulse;
    setup_e            setup_state;
    err_t              err_q;
    logic [STAT_W-1:0] live_stat;
    logic [STAT_W-1:0] snap_q;
    logic [BUS_W-1:0]  stat_word;

    nsr_cmd_decode u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .status_mode   (status_mode),
        .clr_pulse     (clr_pulse),
        .seq_err_pulse (seq_err_pulse),
        .setup_state   (setup_state)
    );

    nsr_err_flags u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr_pulse),
        .seq_err      (seq_err_pulse),
        .prog_fail    (evt_prog_fail),
        .erase_fail   (evt_erase_fail),
        .supply_fault (evt_supply_fault),
        .lock_abort   (evt_lock_abort),
        .err          (err_q)
    );

    always_comb begin
        live_stat            = '0;
        live_stat[B_READY]   = ~eng_busy;
        live_stat[B_ESUSP]   = eng_erase_susp;
        live_stat[B_ERASE]   = err_q.erase;
        live_stat[B_PROG]    = err_q.prog;
        live_stat[B_SUPPLY]  = err_q.supply;
        live_stat[B_PSUSP]   = eng_prog_susp;
        live_stat[B_LOCK]    = err_q.lock;
        live_stat[B_BUFPROG] = eng_bufprog_busy;
    end

    nsr_snapshot #(
        .SNAP_W  (STAT_W),
        .RST_VAL (STAT_RESET)
    ) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live_stat),
        .burst_mode (burst_mode),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .adv_n      (adv_n),
        .snap       (snap_q)
    );

    generate
        if (BUS_W > STAT_W) begin : g_pad
            assign stat_word = {{PAD_W{1'b0}}, snap_q};
        end else begin : g_trim
            assign stat_word = snap_q[BUS_W-1:0];
        end
    endgenerate

    assign dq_rd = status_mode ? stat_word : array_rd;

endmodule

// File: rtl/nor_status_port_chk.sv
module nor_status_port_chk
    import nsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_code,
    input logic              burst_mode,
    input logic              ce_n,
    input logic              oe_n,
    input logic              adv_n,
    input logic              status_mode,
    input logic [BUS_W-1:0]  dq_rd,
    input setup_e            setup_state,
    input logic [3:0]        err_bits,
    input logic [STAT_W-1:0] snap
);

    // R1: first cycle out of reset shows array mode and the 0x80 snapshot
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (snap == STAT_RESET && !status_mode));

    // R4: a wrong byte after erase setup raises the sequence-error code
    a_r4_erase_seq_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && setup_state == SETUP_ERASE && cmd_code != CMD_ERASE_CFM)
        |=> (err_bits[3] && err_bits[2] && status_mode));

    // R7: status reads carry zeros above the status byte
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_mode |-> ((dq_rd >> STAT_W) == '0));

    // R9: asynchronous snapshot moves only when a strobe moves
    a_r9_async_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_mode && $stable(ce_n) && $stable(oe_n)) |=> $stable(snap));

    // R10: burst snapshot ignores everything but ce_n and adv_n
    a_r10_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && $stable(ce_n) && $stable(adv_n)) |=> $stable(snap));

    // R11: error bits only drop after a clear command
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_code == CMD_CLR_STATUS && setup_state == SETUP_NONE)
        |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

endmodule

bind nor_status_port nor_status_port_chk #(.BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .burst_mode  (burst_mode),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .adv_n       (adv_n),
    .status_mode (status_mode),
    .dq_rd       (dq_rd),
    .setup_state (setup_state),
    .err_bits    (err_q),
    .snap        (snap_q)
);

// File: tb/nor_status_port_tb.sv
module nor_status_port_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        eng_busy = 1'b0, eng_erase_susp = 1'b0, eng_prog_susp = 1'b0, eng_bufprog_busy = 1'b0;
    logic        evt_prog_fail = 1'b0, evt_erase_fail = 1'b0, evt_supply_fault = 1'b0, evt_lock_abort = 1'b0;
    logic        burst_mode = 1'b0, ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
    logic [15:0] array_rd = 16'h1234;
    logic [15:0] dq_rd;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nor_status_port #(.BUS_W(16)) u_dut (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic rd_async(input logic [7:0] exp, input string req);
        ce_n = 1'b0;
        step();
        oe_n = 1'b0;
        step();
        chk(dq_rd, {8'h00, exp}, req);
        oe_n = 1'b1;
        ce_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk(dq_rd, 16'h1234, "R1 array mode after reset");
        cmd(8'h70);
        rd_async(8'h80, "R1 R7 reset status word");
    endtask

    task automatic t_program();
        cmd(8'h40);
        eng_busy = 1'b1;
        rd_async(8'h00, "R2 busy clears bit7");
        eng_busy = 1'b0;
        evt_prog_fail = 1'b1; step(); evt_prog_fail = 1'b0;
        rd_async(8'h90, "R3 program error code 01");
        cmd(8'h50);
        rd_async(8'h80, "R12 clear after program error");
    endtask

    task automatic t_erase_resume();
        cmd(8'h20); cmd(8'hD0);
        evt_erase_fail = 1'b1; step(); evt_erase_fail = 1'b0;
        rd_async(8'hA0, "R3 erase error code 10");
        eng_erase_susp = 1'b1;
        rd_async(8'hE0, "R5 erase suspend bit6");
        eng_erase_susp = 1'b0;
        rd_async(8'hA0, "R11 error kept after resume");
    endtask

    task automatic t_seq_in_suspend();
        eng_erase_susp = 1'b1;
        cmd(8'h50);
        rd_async(8'hC0, "R12 clear keeps suspend bit");
        cmd(8'h60); cmd(8'h99);
        rd_async(8'hF0, "R4 lock sequence error in suspend");
        eng_erase_susp = 1'b0;
        rd_async(8'hB0, "R11 sequence error kept after resume");
        cmd(8'h50);
        cmd(8'h20); cmd(8'hFF);
        rd_async(8'hB0, "R4 erase sequence error, FF not executed");
        cmd(8'h50);
    endtask

    task automatic t_lock_supply();
        cmd(8'h60); cmd(8'h01);
        evt_lock_abort = 1'b1; step(); evt_lock_abort = 1'b0;
        evt_supply_fault = 1'b1; step(); evt_supply_fault = 1'b0;
        rd_async(8'h8A, "R6 supply and lock bits");
        cmd(8'h50);
        rd_async(8'h80, "R12 clear drops bits 3 and 1");
        evt_supply_fault = 1'b1;
        cmd(8'h50);
        evt_supply_fault = 1'b0;
        rd_async(8'h88, "R12 event beats coincident clear");
        cmd(8'h50);
    endtask

    task automatic t_live_bits();
        eng_prog_susp = 1'b1;
        rd_async(8'h84, "R5 program suspend bit2");
        eng_prog_susp = 1'b0;
        eng_bufprog_busy = 1'b1;
        rd_async(8'h81, "R5 buffered programming bit0");
        eng_bufprog_busy = 1'b0;
    endtask

    task automatic t_async_first_edge();
        ce_n = 1'b0; step();
        evt_prog_fail = 1'b1; step(); evt_prog_fail = 1'b0;
        oe_n = 1'b0; step();
        chk(dq_rd, 16'h0080, "R9 later oe fall keeps first snapshot");
        oe_n = 1'b1; step();
        oe_n = 1'b0; step();
        chk(dq_rd, 16'h0090, "R9 new oe cycle retakes snapshot");
        oe_n = 1'b1; ce_n = 1'b1; step();
        cmd(8'h50);
    endtask

    task automatic t_burst();
        burst_mode = 1'b1; step();
        ce_n = 1'b0; step();
        evt_supply_fault = 1'b1; step(); evt_supply_fault = 1'b0;
        oe_n = 1'b0; step();
        chk(dq_rd, 16'h0080, "R10 oe fall does not refresh");
        oe_n = 1'b1; step();
        oe_n = 1'b0; step();
        chk(dq_rd, 16'h0080, "R10 oe toggle does not refresh");
        adv_n = 1'b0; step();
        adv_n = 1'b1; step();
        chk(dq_rd, 16'h0088, "R10 adv fall refreshes");
        evt_lock_abort = 1'b1; step(); evt_lock_abort = 1'b0;
        ce_n = 1'b1; step();
        ce_n = 1'b0; step();
        chk(dq_rd, 16'h008A, "R10 ce fall refreshes");
        ce_n = 1'b1; oe_n = 1'b1; step();
        burst_mode = 1'b0;
        cmd(8'h50);
    endtask

    task automatic t_array();
        cmd(8'hFF);
        chk(dq_rd, 16'h1234, "R8 read array passes array data");
        array_rd = 16'hBEEF; step();
        chk(dq_rd, 16'hBEEF, "R8 array data followed");
        cmd(8'h33);
        chk(dq_rd, 16'hBEEF, "R8 unknown code keeps array mode");
        cmd(8'h70);
        rd_async(8'h80, "R8 read status from array mode");
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_program();
        t_erase_resume();
        t_seq_in_suspend();
        t_lock_supply();
        t_live_bits();
        t_async_first_edge();
        t_burst();
        t_array();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got hung expected done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule